// File: doc/BRIEF.md
# Priority Reference Source Selector

This block chooses which of several timing reference inputs a clock recovery loop should follow. Each input has a priority code that software writes and an activity flag that comes from a slow activity monitor. The input now in use is also judged by two flags from the loop itself: phase health and whether its frequency sits inside the loop's capture range. Each clock cycle the selector works out which inputs are eligible and picks the best one. It then reports the chosen index, a flag saying that no input is usable, and a one-cycle pulse whenever the choice changes. The clock multiplexer that acts on the index is outside this block.

An input that is not in use needs only its activity flag to stay eligible. The input in use can also be dropped when the loop reports a phase fault or an out-of-range frequency. Such a drop is remembered in a per-input rejection table, so the selector does not swing straight back to it. A rejection is cleared when the activity monitor withdraws the input or when software gives it priority zero. For testing, a force index selects an input outright. A hold mode freezes the current choice.

All pins are plain control and status levels, with no stream handshake. Every output is registered, so an output reflects the inputs sampled at the previous rising edge.

Top module: `ref_src_selector`

## Requirements
- R1: In automatic operation the selector picks, among eligible inputs, the one with the lowest nonzero priority code. When codes are equal, the lowest input index wins. Input k's code sits at bits [4k+3:4k] of `prio_tbl`.
- R2: An input whose priority code is 0 is never eligible, even when it is the input in use.
- R3: For an input that is not in use, `sel_phase_ok` and `sel_in_range` have no effect. It is eligible when its code is nonzero, its `act_ok` bit is 1 and it is not rejected.
- R4: The input in use loses eligibility when its `act_ok` bit is 0, when `sel_phase_ok` is 0 or when `sel_in_range` is 0. The best remaining eligible input is then selected at the next edge.
- R5: An input that is in use while `sel_phase_ok` or `sel_in_range` is 0 becomes rejected and stays ineligible. The rejection ends once its `act_ok` bit is seen at 0 or its priority code is seen at 0, and the input is eligible again from the following cycle.
- R6: When automatic operation finds no eligible input, `none_valid` is 1 and `sel_idx` keeps its previous value.
- R7: `sw_pulse` is 1 for exactly the one cycle in which `sel_idx` takes a value different from the cycle before, and 0 otherwise.
- R8: A `force_idx` value below 6 selects that input whatever its eligibility, with `none_valid` at 0.
- R9: A `force_idx` value of 6 or 7 has no effect, and automatic selection applies.
- R10: `op_mode` = 1 (hold) freezes `sel_idx` and `none_valid` with no pulse. Values 0, 2 and 3 mean automatic operation. A force index that is in range takes precedence over hold.
- R11: While `rst_n` is low the outputs are `sel_idx` = 0, `none_valid` = 1 and `sw_pulse` = 0, and all rejections are cleared.
- R12: Outputs change only at a rising clock edge, one cycle after the inputs that cause the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prio_tbl | input | 24 | Priority codes, 4 bits per input, input 0 in the low nibble |
| act_ok | input | 6 | Activity monitor verdict per input, 1 = active |
| sel_phase_ok | input | 1 | Phase health of the input in use |
| sel_in_range | input | 1 | Input in use lies inside the loop capture range |
| force_idx | input | 3 | Forced input index. Values 6 and 7 mean no force |
| op_mode | input | 2 | 1 = hold. Any other value means automatic |
| sel_idx | output | 3 | Selected input index |
| none_valid | output | 1 | No eligible input in automatic operation |
| sw_pulse | output | 1 | One-cycle pulse on each change of the selected index |

## Verification
A wrong rejection bit shows up as the selector skipping an input that should win, or returning to one that should stay excluded. This is visible on `sel_idx` at the first edge after the flags change, which is why the stimulus first provokes rejections and then clears them by withdrawing activity. A stale selected-index register shows as a missing or spurious `sw_pulse` in the same cycle. A bad eligibility mask shows as `none_valid` asserting while a usable input is present. Because the block has a single register stage, every such fault reaches the ports within one cycle of its cause.

// File: rtl/ref_src_selector_pkg.sv
package ref_src_selector_pkg;

  typedef enum logic [1:0] {
    OPM_AUTO  = 2'd0,
    OPM_HOLD  = 2'd1,
    OPM_RSV_A = 2'd2,
    OPM_RSV_B = 2'd3
  } opmode_e;

endpackage

// File: rtl/ref_eligibility.sv
// Per-input eligibility with a sticky rejection table for inputs that
// failed phase or range checks while in use.
module ref_eligibility #(
  parameter int N_REF  = 6,
  parameter int PRIO_W = 4,
  parameter int SEL_W  = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_REF*PRIO_W-1:0] prio_tbl,
  input  logic [N_REF-1:0]        act_ok,
  input  logic [SEL_W-1:0]        cur_idx,
  input  logic                    sel_phase_ok,
  input  logic                    sel_in_range,
  output logic [N_REF-1:0]        eligible
);

  logic loop_healthy;
  assign loop_healthy = sel_phase_ok & sel_in_range;

  for (genvar g = 0; g < N_REF; g++) begin : g_in
    logic              rej_q;
    logic              in_use;
    logic              has_prio;
    logic [PRIO_W-1:0] code;

    assign code     = prio_tbl[g*PRIO_W +: PRIO_W];
    assign has_prio = (code != '0);
    assign in_use   = (cur_idx == SEL_W'(g));

    // Clearing wins over setting: withdrawal by the monitor or by software
    // gives the input a fresh start.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rej_q <= 1'b0;
      end else if (!act_ok[g] || !has_prio) begin
        rej_q <= 1'b0;
      end else if (in_use && !loop_healthy) begin
        rej_q <= 1'b1;
      end
    end

    assign eligible[g] = has_prio & act_ok[g] & ~rej_q & (~in_use | loop_healthy);
  end

endmodule

// File: rtl/ref_prio_pick.sv
// Finds the eligible input with the lowest nonzero code; ties go to the
// lowest index because only a strictly better code replaces the incumbent.
module ref_prio_pick #(
  parameter int N_REF  = 6,
  parameter int PRIO_W = 4,
  parameter int SEL_W  = 3
) (
  input  logic [N_REF*PRIO_W-1:0] prio_tbl,
  input  logic [N_REF-1:0]        eligible,
  output logic                    found,
  output logic [SEL_W-1:0]        pick_idx
);

  logic [PRIO_W-1:0] best;

  always_comb begin
    found    = 1'b0;
    pick_idx = '0;
    best     = '1;
    for (int i = 0; i < N_REF; i++) begin
      if (eligible[i] && (!found || (prio_tbl[i*PRIO_W +: PRIO_W] < best))) begin
        found    = 1'b1;
        best     = prio_tbl[i*PRIO_W +: PRIO_W];
        pick_idx = SEL_W'(i);
      end
    end
  end

endmodule

// File: rtl/ref_sel_ctrl.sv
// Resolves force, hold and automatic choice and registers the outputs.
module ref_sel_ctrl
  import ref_src_selector_pkg::*;
#(
  parameter int N_REF = 6,
  parameter int SEL_W = 3,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             found,
  input  logic [SEL_W-1:0] pick_idx,
  input  logic [IDX_W-1:0] force_idx,
  input  logic [1:0]       op_mode,
  output logic [SEL_W-1:0] sel_q,
  output logic             none_q,
  output logic             sw_q
);

  localparam logic [IDX_W-1:0] FORCE_LIM = IDX_W'(N_REF);

  logic             force_hit;
  logic             hold_req;
  logic [SEL_W-1:0] sel_d;
  logic             none_d;

  assign force_hit = (force_idx < FORCE_LIM);
  assign hold_req  = (opmode_e'(op_mode) == OPM_HOLD);

  always_comb begin
    sel_d  = sel_q;
    none_d = none_q;
    if (force_hit) begin
      sel_d  = SEL_W'(force_idx);
      none_d = 1'b0;
    end else if (!hold_req) begin
      if (found) begin
        sel_d  = pick_idx;
        none_d = 1'b0;
      end else begin
        none_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      none_q <= 1'b1;
      sw_q   <= 1'b0;
    end else begin
      sel_q  <= sel_d;
      none_q <= none_d;
      sw_q   <= (sel_d != sel_q);
    end
  end

endmodule

// File: rtl/ref_src_selector.sv
module ref_src_selector #(
  parameter int N_REF  = 6,
  parameter int PRIO_W = 4,
  parameter int SEL_W  = $clog2(N_REF),
  parameter int IDX_W  = $clog2(N_REF + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_REF*PRIO_W-1:0] prio_tbl,
  input  logic [N_REF-1:0]        act_ok,
  input  logic                    sel_phase_ok,
  input  logic                    sel_in_range,
  input  logic [IDX_W-1:0]        force_idx,
  input  logic [1:0]              op_mode,
  output logic [SEL_W-1:0]        sel_idx,
  output logic                    none_valid,
  output logic                    sw_pulse
);

  logic [N_REF-1:0] eligible;
  logic             found;
  logic [SEL_W-1:0] pick_idx;

  ref_eligibility #(.N_REF(N_REF), .PRIO_W(PRIO_W), .SEL_W(SEL_W)) u_elig (
    .clk          (clk),
    .rst_n        (rst_n),
    .prio_tbl     (prio_tbl),
    .act_ok       (act_ok),
    .cur_idx      (sel_idx),
    .sel_phase_ok (sel_phase_ok),
    .sel_in_range (sel_in_range),
    .eligible     (eligible)
  );

  ref_prio_pick #(.N_REF(N_REF), .PRIO_W(PRIO_W), .SEL_W(SEL_W)) u_pick (
    .prio_tbl (prio_tbl),
    .eligible (eligible),
    .found    (found),
    .pick_idx (pick_idx)
  );

  ref_sel_ctrl #(.N_REF(N_REF), .SEL_W(SEL_W), .IDX_W(IDX_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .found     (found),
    .pick_idx  (pick_idx),
    .force_idx (force_idx),
    .op_mode   (op_mode),
    .sel_q     (sel_idx),
    .none_q    (none_valid),
    .sw_q      (sw_pulse)
  );

endmodule

// File: rtl/ref_src_selector_chk.sv
module ref_src_selector_chk #(
  parameter int N_REF = 6,
  parameter int SEL_W = 3,
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [IDX_W-1:0] force_idx,
  input logic [1:0]       op_mode,
  input logic [SEL_W-1:0] sel_idx,
  input logic             none_valid,
  input logic             sw_pulse
);

  localparam logic [IDX_W-1:0] FLIM = IDX_W'(N_REF);
  localparam logic [SEL_W:0]   SLIM = (SEL_W+1)'(N_REF);

  AST_SEL_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, sel_idx} < SLIM); // R1

  AST_PULSE_MEANS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    sw_pulse |-> (sel_idx != $past(sel_idx))); // R7

  AST_CHANGE_MEANS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_idx != $past(sel_idx)) |-> sw_pulse); // R7

  AST_NONE_KEEPS_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    none_valid |-> !sw_pulse); // R6

  AST_FORCE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && ($past(force_idx) < FLIM)) |->
      ((sel_idx == SEL_W'($past(force_idx))) && !none_valid)); // R8

  AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && ($past(op_mode) == 2'd1) && ($past(force_idx) >= FLIM)) |->
      ($stable(sel_idx) && $stable(none_valid) && !sw_pulse)); // R10

endmodule

bind ref_src_selector ref_src_selector_chk #(
  .N_REF(N_REF), .SEL_W(SEL_W), .IDX_W(IDX_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .force_idx  (force_idx),
  .op_mode    (op_mode),
  .sel_idx    (sel_idx),
  .none_valid (none_valid),
  .sw_pulse   (sw_pulse)
);

// File: tb/tb_ref_src_selector.sv
`timescale 1ns/1ps
module tb_ref_src_selector;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] prio_tbl = '0;
  logic [5:0]  act_ok = '0;
  logic        sel_phase_ok = 1'b1;
  logic        sel_in_range = 1'b1;
  logic [2:0]  force_idx = 3'd7;
  logic [1:0]  op_mode = 2'd0;
  logic [2:0]  sel_idx;
  logic        none_valid;
  logic        sw_pulse;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ref_src_selector dut (
    .clk(clk), .rst_n(rst_n), .prio_tbl(prio_tbl), .act_ok(act_ok),
    .sel_phase_ok(sel_phase_ok), .sel_in_range(sel_in_range),
    .force_idx(force_idx), .op_mode(op_mode),
    .sel_idx(sel_idx), .none_valid(none_valid), .sw_pulse(sw_pulse)
  );

  typedef struct packed {
    logic [23:0] prio;
    logic [5:0]  act;
    logic        ph;
    logic        rg;
    logic [2:0]  frc;
    logic [1:0]  mode;
    logic [2:0]  esel;
    logic        enone;
    logic        esw;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{24'h150213, 6'h3F, 1'b1, 1'b1, 3'd7, 2'd0, 3'd1, 1'b0, 1'b1, 4'd1},  // R1 tie in1/in5 -> in1
    '{24'h150213, 6'h3F, 1'b1, 1'b1, 3'd7, 2'd0, 3'd1, 1'b0, 1'b0, 4'd7},  // R7 no change, no pulse
    '{24'h150213, 6'h3D, 1'b1, 1'b1, 3'd7, 2'd0, 3'd5, 1'b0, 1'b1, 4'd4},  // R4 in1 inactive
    '{24'h150213, 6'h3F, 1'b1, 1'b1, 3'd7, 2'd0, 3'd1, 1'b0, 1'b1, 4'd1},  // R1 in1 back, wins tie
    '{24'h150213, 6'h3F, 1'b0, 1'b1, 3'd7, 2'd0, 3'd5, 1'b0, 1'b1, 4'd4},  // R4 phase fault
    '{24'h150213, 6'h3F, 1'b0, 1'b1, 3'd7, 2'd0, 3'd2, 1'b0, 1'b1, 4'd3},  // R3 in2 ignores phase flag
    '{24'h150213, 6'h3F, 1'b1, 1'b0, 3'd7, 2'd0, 3'd0, 1'b0, 1'b1, 4'd4},  // R4 out of range
    '{24'h150213, 6'h3F, 1'b1, 1'b1, 3'd7, 2'd0, 3'd0, 1'b0, 1'b0, 4'd5},  // R5 rejected stay out
    '{24'h150213, 6'h3D, 1'b1, 1'b1, 3'd7, 2'd0, 3'd0, 1'b0, 1'b0, 4'd5},  // R5 in1 withdrawn
    '{24'h150213, 6'h3F, 1'b1, 1'b1, 3'd7, 2'd0, 3'd1, 1'b0, 1'b1, 4'd5},  // R5 in1 readmitted
    '{24'h150203, 6'h3F, 1'b1, 1'b1, 3'd7, 2'd0, 3'd0, 1'b0, 1'b1, 4'd2},  // R2 code 0 drops in use
    '{24'h150203, 6'h00, 1'b1, 1'b1, 3'd7, 2'd0, 3'd0, 1'b1, 1'b0, 4'd6},  // R6 none eligible
    '{24'h150203, 6'h00, 1'b1, 1'b1, 3'd4, 2'd0, 3'd4, 1'b0, 1'b1, 4'd8},  // R8 force to dead input
    '{24'h150203, 6'h00, 1'b1, 1'b1, 3'd6, 2'd0, 3'd4, 1'b1, 1'b0, 4'd9},  // R9 force 6 ignored
    '{24'h150203, 6'h3F, 1'b1, 1'b1, 3'd7, 2'd1, 3'd4, 1'b1, 1'b0, 4'd10}, // R10 hold freezes
    '{24'h150203, 6'h3F, 1'b1, 1'b1, 3'd3, 2'd1, 3'd3, 1'b0, 1'b1, 4'd10}, // R10 force beats hold
    '{24'h150203, 6'h3F, 1'b1, 1'b1, 3'd7, 2'd2, 3'd5, 1'b0, 1'b1, 4'd5}   // R5 activity drop cleared all
  };

  task automatic chk(input string req, input string what, input int got, input int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11", "sel_idx", sel_idx, 0);
    chk("R11", "none_valid", none_valid, 1);
    chk("R11", "sw_pulse", sw_pulse, 0);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      prio_tbl     = VEC[v].prio;
      act_ok       = VEC[v].act;
      sel_phase_ok = VEC[v].ph;
      sel_in_range = VEC[v].rg;
      force_idx    = VEC[v].frc;
      op_mode      = VEC[v].mode;
      @(negedge clk);
      chk($sformatf("R%0d v%0d", VEC[v].req, v), "sel_idx", sel_idx, VEC[v].esel);
      chk($sformatf("R%0d v%0d", VEC[v].req, v), "none_valid", none_valid, VEC[v].enone);
      chk($sformatf("R%0d v%0d", VEC[v].req, v), "sw_pulse", sw_pulse, VEC[v].esw);
    end

    // R12 nothing moves before the edge
    force_idx = 3'd2;
    #1;
    chk("R12", "sel_idx before edge", sel_idx, 5);
    @(negedge clk);
    chk("R12", "sel_idx after edge", sel_idx, 2);
    chk("R12", "sw_pulse after edge", sw_pulse, 1);
    @(negedge clk);
    chk("R7", "pulse lasts one cycle", sw_pulse, 0);

    // R1 equal top-range codes on in3 and in4: lowest index
    force_idx = 3'd7;
    op_mode   = 2'd3;
    prio_tbl  = 24'h0FF000;
    act_ok    = 6'h3F;
    @(negedge clk);
    chk("R1", "tie at code 15", sel_idx, 3);
    chk("R1", "tie none_valid", none_valid, 0);

    // R3 range flag ignored for in4 while in3 is dropped
    sel_in_range = 1'b0;
    @(negedge clk);
    chk("R3", "next input despite range flag", sel_idx, 4);

    // R11 reset mid-run
    rst_n = 1'b0;
    #1;
    chk("R11", "async sel_idx", sel_idx, 0);
    chk("R11", "async none_valid", none_valid, 1);
    chk("R11", "async sw_pulse", sw_pulse, 0);
    @(negedge clk);
    rst_n = 1'b1;
    sel_in_range = 1'b1;
    prio_tbl = 24'h000001;
    @(negedge clk);
    chk("R11", "rejections cleared by reset", sel_idx, 0);
    chk("R11", "in0 eligible after reset", none_valid, 0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule